// File: doc/BRIEF.md
# PCM Voice Serial Port

This block carries one voice sample each way per 8 kHz frame between an external codec and the rest of the chip. The codec side has four signals: a bit clock, a frame sync, serial data in and serial data out. The chip side is parallel. One 16-bit transmit word is captured per frame, and one 16-bit receive word is returned per frame. Each has a single-cycle strobe.

The bit clock and the frame sync can come from the codec (slave), or the block can generate both by dividing the system clock (master). A configuration register selects master or slave, the frame format, the sample width and two mute controls. In the short format, the sync pulse lasts one bit clock and the first data bit follows on the next clock. In the long format, the first data bit goes out on the clock where sync first rises. Serial output changes on the rising edge of the bit clock. Serial input is sampled on the falling edge. Samples travel MSB first.

All logic runs on the system clock. In slave mode the codec pins pass through two-stage synchronisers before their edges are detected.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, both clock and sync output enables are low (slave), serial out is low, rx_word is zero and both strobes are low. The configuration defaults to short format, 8-bit width, and both mutes off.
- R2: A cycle with cfg_we high loads all configuration fields. The output enables of clock and sync follow the stored master bit, and the enables never rise without such a write.
- R3: In master mode the bit clock period is 2*DIV_HALF system cycles, and the sync rises once every FRAME_BITS bit clocks.
- R4: In master mode the sync rises together with a bit-clock rising edge. It stays high for 1 bit clock in short format and 3 bit clocks in long format.
- R5: Serial out changes only on bit-clock rising edges and sends the slot MSB first. In short format the MSB goes out on the clock after the sync clock. In long format it goes out on the clock where sync is first sampled high.
- R6: Serial in is sampled on bit-clock falling edges, MSB first. One rx_stb pulse with the assembled rx_word follows the falling edge of the last slot bit.
- R7: Width code 00 selects an 8-bit slot: tx_word[7:0] is sent, and the sample returns in rx_word[7:0] with rx_word[15:8] zero. Code 01 selects 14-bit samples in a 16-bit slot: tx_word[15:2] is sent, the last two slot bits are driven 0, and rx_word[1:0] reads 0. Codes 10 and 11 select 16-bit samples.
- R8: With transmit mute on, every slot bit is driven 0 whatever tx_word holds.
- R9: With receive mute on, rx_stb still pulses once per frame but rx_word reads zero.
- R10: In slave long format, a sync pulse of any length from one bit clock up to half a frame starts exactly one frame, on the first rising edge where sync is sampled high.
- R11: frame_stb pulses for exactly one cycle, once per frame, when the transmit word is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_master | input | 1 | 1: generate bit clock and sync |
| cfg_long | input | 1 | 1: long frame format, 0: short |
| cfg_width | input | 2 | Sample width code (00 8-bit, 01 14-bit, 1x 16-bit) |
| cfg_tx_mute | input | 1 | Drive zeros in the transmit slot |
| cfg_rx_mute | input | 1 | Return zero receive words |
| tx_word | input | 16 | Transmit sample, captured once per frame |
| frame_stb | output | 1 | Pulse: tx_word captured |
| rx_word | output | 16 | Last received sample |
| rx_stb | output | 1 | Pulse: rx_word updated |
| pcm_clk_i | input | 1 | Bit clock from codec (slave) |
| pcm_clk_o | output | 1 | Generated bit clock (master) |
| pcm_clk_oe | output | 1 | Output enable for the bit clock pad |
| pcm_sync_i | input | 1 | Frame sync from codec (slave) |
| pcm_sync_o | output | 1 | Generated frame sync (master) |
| pcm_sync_oe | output | 1 | Output enable for the sync pad |
| pcm_din | input | 1 | Serial data from codec |
| pcm_dout | output | 1 | Serial data to codec |

## Verification
In slave mode, a codec pin edge reaches the block's registers on the third system clock edge after the pin changes. Serial out therefore settles three cycles after a bit-clock rise, and rx_stb rises three cycles after the last falling edge. In master mode, serial out changes on the same edge that raises pcm_clk_o, and rx_word updates on the edge that lowers it. The bench model of the codec samples serial out only at the end of each high phase, which is six cycles into the phase in slave mode. It changes serial in and sync only at the opposite edge, so both latencies sit well inside the half period. Receive words are queued in frame order when the frame is driven and are compared whenever rx_stb arrives, so the exact arrival cycle does not matter while the order does.

// File: rtl/pcm_port_pkg.sv
// Shared types and slot formatting helpers for the PCM voice serial port.
// Assumes slots are at most 16 bits wide and samples are carried MSB first.
package pcm_port_pkg;

    typedef enum logic [1:0] {
        PW_8   = 2'b00,
        PW_14  = 2'b01,
        PW_16  = 2'b10,
        PW_16B = 2'b11
    } pcm_width_e;

    typedef struct packed {
        logic       master;
        logic       long_fmt;
        pcm_width_e width;
        logic       tx_mute;
        logic       rx_mute;
    } pcm_cfg_t;

    // Number of bit clocks in one data slot.
    function automatic logic [4:0] slot_len(input pcm_width_e w);
        return (w == PW_8) ? 5'd8 : 5'd16;
    endfunction

    // Left-align a transmit sample so bit 15 leaves first.
    function automatic logic [15:0] tx_align(input pcm_width_e w, input logic [15:0] d);
        case (w)
            PW_8:    return {d[7:0], 8'h00};
            PW_14:   return {d[15:2], 2'b00};
            default: return d;
        endcase
    endfunction

    // Turn the raw receive shift register into the parallel word.
    function automatic logic [15:0] rx_format(input pcm_width_e w, input logic [15:0] s);
        case (w)
            PW_8:    return {8'h00, s[7:0]};
            PW_14:   return {s[15:2], 2'b00};
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/pcm_bit_timing.sv
// Bit-clock event source. In master mode it divides the system clock into
// a bit clock and frame sync; in slave mode it synchronises the codec pins.
// Either way it yields one-cycle rise/fall events plus a frame-start flag
// valid with the rise event. Assumes DIV_HALF >= 2 and FRAME_BITS >= 4.
module pcm_bit_timing #(
    parameter int DIV_HALF   = 48,
    parameter int FRAME_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic long_fmt,
    input  logic clk_pin,
    input  logic sync_pin,
    input  logic din_pin,
    output logic rise_evt,
    output logic fall_evt,
    output logic frame_start,
    output logic din_s,
    output logic bclk_o,
    output logic sync_o
);
    localparam int HCW = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;
    localparam int FPW = $clog2(FRAME_BITS);

    logic [2:0]     c_sh;
    logic [1:0]     s_sh;
    logic [1:0]     d_sh;
    logic           sync_prev;
    logic [HCW-1:0] hc;
    logic [FPW-1:0] fpos;
    logic [FPW-1:0] fpos_nx;
    logic           tick;

    // Two-stage synchronisers for the codec pins, plus one extra clock stage for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_sh <= '0;
            s_sh <= '0;
            d_sh <= '0;
        end else begin
            c_sh <= {c_sh[1:0], clk_pin};
            s_sh <= {s_sh[0], sync_pin};
            d_sh <= {d_sh[0], din_pin};
        end
    end

    assign tick    = master && (hc == HCW'(DIV_HALF - 1));
    assign fpos_nx = (fpos == FPW'(FRAME_BITS - 1)) ? '0 : fpos + 1'b1;

    // Master divider: bit clock, bit position in frame and sync level.
    always_ff @(posedge clk) begin
        if (!rst_n || !master) begin
            hc     <= '0;
            bclk_o <= 1'b0;
            fpos   <= FPW'(FRAME_BITS - 1);
            sync_o <= 1'b0;
        end else begin
            hc <= tick ? '0 : hc + 1'b1;
            if (tick) bclk_o <= !bclk_o;
            if (tick && !bclk_o) begin
                fpos   <= fpos_nx;
                sync_o <= long_fmt ? (fpos_nx < FPW'(3)) : (fpos_nx == '0);
            end
        end
    end

    // Slave sync level as seen at the previous bit-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev <= 1'b0;
        else if (!master && c_sh[1] && !c_sh[2]) sync_prev <= s_sh[1];
    end

    assign rise_evt    = master ? (tick && !bclk_o) : (c_sh[1] && !c_sh[2]);
    assign fall_evt    = master ? (tick && bclk_o)  : (!c_sh[1] && c_sh[2]);
    assign frame_start = master ? (fpos_nx == '0)   : (s_sh[1] && !sync_prev);
    assign din_s       = d_sh[1];

endmodule

// File: rtl/pcm_tx_path.sv
// Transmit shifter. Captures the parallel word at the start of the data slot
// (frame-start rise in long format, the following rise in short format) and
// shifts it out MSB first on bit-clock rises, driving 0 outside the slot.
module pcm_tx_path
    import pcm_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_evt,
    input  logic        frame_start,
    input  logic        long_fmt,
    input  pcm_width_e  width,
    input  logic        mute,
    input  logic [15:0] tx_word,
    output logic        load,
    output logic        load_q,
    output logic        dout
);
    logic        arm;
    logic [15:0] sh;
    logic [4:0]  left;
    logic [15:0] word;

    assign load = rise_evt && (long_fmt ? frame_start : arm);
    assign word = mute ? '0 : tx_align(width, tx_word);

    // Slot sequencing and serial output, advanced on each bit-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm  <= 1'b0;
            sh   <= '0;
            left <= '0;
            dout <= 1'b0;
        end else if (rise_evt) begin
            arm <= !long_fmt && frame_start;
            if (load) begin
                dout <= word[15];
                sh   <= {word[14:0], 1'b0};
                left <= slot_len(width) - 5'd1;
            end else if (left != '0) begin
                dout <= sh[15];
                sh   <= {sh[14:0], 1'b0};
                left <= left - 5'd1;
            end else begin
                dout <= 1'b0;
            end
        end
    end

    // Registered capture strobe for the parallel side.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= load;
    end

endmodule

// File: rtl/pcm_rx_path.sv
// Receive shifter. Armed by the transmit capture pulse, it samples the
// serial input on each bit-clock fall for one slot and then presents the
// formatted word with a one-cycle strobe.
module pcm_rx_path
    import pcm_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        fall_evt,
    input  pcm_width_e  width,
    input  logic        mute,
    input  logic        din,
    output logic [15:0] rx_word,
    output logic        rx_stb
);
    logic [15:0] sh;
    logic [4:0]  left;
    logic [15:0] full;

    assign full = {sh[14:0], din};

    // Collect one slot of bits and publish the word on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            left    <= '0;
            rx_word <= '0;
            rx_stb  <= 1'b0;
        end else begin
            rx_stb <= 1'b0;
            if (start) begin
                left <= slot_len(width);
            end else if (fall_evt && left != '0) begin
                sh   <= full;
                left <= left - 5'd1;
                if (left == 5'd1) begin
                    rx_word <= mute ? '0 : rx_format(width, full);
                    rx_stb  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_voice_port.sv
// PCM voice serial port top. Holds the configuration register and connects
// the bit timing source to the transmit and receive shifters. Assumes the
// pad ring combines *_o and *_oe with the *_i inputs.
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int DIV_HALF   = 48,
    parameter int FRAME_BITS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_master,
    input  logic        cfg_long,
    input  logic [1:0]  cfg_width,
    input  logic        cfg_tx_mute,
    input  logic        cfg_rx_mute,
    input  logic [15:0] tx_word,
    output logic        frame_stb,
    output logic [15:0] rx_word,
    output logic        rx_stb,
    input  logic        pcm_clk_i,
    output logic        pcm_clk_o,
    output logic        pcm_clk_oe,
    input  logic        pcm_sync_i,
    output logic        pcm_sync_o,
    output logic        pcm_sync_oe,
    input  logic        pcm_din,
    output logic        pcm_dout
);
    pcm_cfg_t cfg_q;
    logic     rise_evt, fall_evt, frame_start, din_s, load;

    // Configuration register, loaded whole on a write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{master: 1'b0, long_fmt: 1'b0, width: PW_8, tx_mute: 1'b0, rx_mute: 1'b0};
        end else if (cfg_we) begin
            cfg_q <= '{master: cfg_master, long_fmt: cfg_long, width: pcm_width_e'(cfg_width),
                       tx_mute: cfg_tx_mute, rx_mute: cfg_rx_mute};
        end
    end

    assign pcm_clk_oe  = cfg_q.master;
    assign pcm_sync_oe = cfg_q.master;

    pcm_bit_timing #(.DIV_HALF(DIV_HALF), .FRAME_BITS(FRAME_BITS)) u_timing (
        .clk(clk), .rst_n(rst_n), .master(cfg_q.master), .long_fmt(cfg_q.long_fmt),
        .clk_pin(pcm_clk_i), .sync_pin(pcm_sync_i), .din_pin(pcm_din),
        .rise_evt(rise_evt), .fall_evt(fall_evt), .frame_start(frame_start),
        .din_s(din_s), .bclk_o(pcm_clk_o), .sync_o(pcm_sync_o)
    );

    pcm_tx_path u_tx (
        .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .frame_start(frame_start),
        .long_fmt(cfg_q.long_fmt), .width(cfg_q.width), .mute(cfg_q.tx_mute),
        .tx_word(tx_word), .load(load), .load_q(frame_stb), .dout(pcm_dout)
    );

    pcm_rx_path u_rx (
        .clk(clk), .rst_n(rst_n), .start(load), .fall_evt(fall_evt),
        .width(cfg_q.width), .mute(cfg_q.rx_mute), .din(din_s),
        .rx_word(rx_word), .rx_stb(rx_stb)
    );

endmodule

// File: rtl/pcm_voice_port_chk.sv
// Assertion checker for pcm_voice_port, attached by bind. It observes the
// ports and the stored configuration and counts master-mode sync width.
module pcm_voice_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic        cfg_master,
    input logic        long_fmt,
    input logic        rxm,
    input logic        w8,
    input logic        frame_stb,
    input logic [15:0] rx_word,
    input logic        rx_stb,
    input logic        pcm_clk_o,
    input logic        pcm_clk_oe,
    input logic        pcm_sync_o,
    input logic        pcm_sync_oe,
    input logic        pcm_dout
);
    logic       clk_d, sync_d;
    logic [3:0] scnt;

    // Count generated bit-clock rises while the generated sync is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d  <= 1'b0;
            sync_d <= 1'b0;
            scnt   <= '0;
        end else begin
            clk_d  <= pcm_clk_o;
            sync_d <= pcm_sync_o;
            if (pcm_sync_o && !sync_d)                   scnt <= 4'd1;
            else if (pcm_sync_o && pcm_clk_o && !clk_d)  scnt <= scnt + 4'd1;
        end
    end

    p_oe_from_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_clk_oe) |-> $past(cfg_we && cfg_master));

    p_sync_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_sync_oe && $rose(pcm_sync_o)) |-> $rose(pcm_clk_o));

    p_long_sync_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_sync_oe && long_fmt && $fell(pcm_sync_o)) |-> (scnt == 4'd3));

    p_short_sync_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_sync_oe && !long_fmt && $fell(pcm_sync_o)) |-> (scnt == 4'd1));

    p_dout_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_clk_oe && $past(pcm_clk_oe) && (pcm_dout != $past(pcm_dout))) |-> $rose(pcm_clk_o));

    p_rx_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> !rx_stb);

    p_w8_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && $past(w8)) |-> (rx_word[15:8] == 8'h00));

    p_rx_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && $past(rxm)) |-> (rx_word == 16'h0000));

    p_frame_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_master(cfg_master),
    .long_fmt(cfg_q.long_fmt), .rxm(cfg_q.rx_mute), .w8(cfg_q.width == pcm_port_pkg::PW_8),
    .frame_stb(frame_stb), .rx_word(rx_word), .rx_stb(rx_stb),
    .pcm_clk_o(pcm_clk_o), .pcm_clk_oe(pcm_clk_oe), .pcm_sync_o(pcm_sync_o),
    .pcm_sync_oe(pcm_sync_oe), .pcm_dout(pcm_dout)
);

// File: tb/pcm_voice_port_tb.sv
// Scoreboard bench: a codec model drives frames and queues expected receive
// words; a monitor pops and compares them on every rx_stb.
module pcm_voice_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 6;   // slave bit-clock half period, system cycles
    localparam int FB         = 20;  // bit clocks per frame
    localparam int DIVH       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_master = 1'b0, cfg_long = 1'b0;
    logic [1:0]  cfg_width = 2'b00;
    logic        cfg_tx_mute = 1'b0, cfg_rx_mute = 1'b0;
    logic [15:0] tx_word = '0;
    logic        frame_stb, rx_stb;
    logic [15:0] rx_word;
    logic        pcm_clk_i = 1'b0, pcm_sync_i = 1'b0, pcm_din = 1'b0;
    logic        pcm_clk_o, pcm_clk_oe, pcm_sync_o, pcm_sync_oe, pcm_dout;

    int          checks = 0, fails = 0, nstb = 0;
    logic [15:0] q_rx[$];
    string       q_tag[$];
    time         last_sync_t = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_voice_port #(.DIV_HALF(DIVH), .FRAME_BITS(FB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_master(cfg_master),
        .cfg_long(cfg_long), .cfg_width(cfg_width), .cfg_tx_mute(cfg_tx_mute),
        .cfg_rx_mute(cfg_rx_mute), .tx_word(tx_word), .frame_stb(frame_stb),
        .rx_word(rx_word), .rx_stb(rx_stb), .pcm_clk_i(pcm_clk_i), .pcm_clk_o(pcm_clk_o),
        .pcm_clk_oe(pcm_clk_oe), .pcm_sync_i(pcm_sync_i), .pcm_sync_o(pcm_sync_o),
        .pcm_sync_oe(pcm_sync_oe), .pcm_din(pcm_din), .pcm_dout(pcm_dout)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int slot_n(input logic [1:0] w);
        return (w == 2'b00) ? 8 : 16;
    endfunction

    function automatic logic [15:0] exp_serial(input logic [1:0] w, input logic m, input logic [15:0] d);
        if (m) return 16'h0000;
        case (w)
            2'b00:   return {d[7:0], 8'h00};
            2'b01:   return {d[15:2], 2'b00};
            default: return d;
        endcase
    endfunction

    function automatic logic [15:0] exp_rx(input logic [1:0] w, input logic m, input logic [15:0] s);
        if (m) return 16'h0000;
        case (w)
            2'b00:   return {8'h00, s[15:8]};
            2'b01:   return {s[15:2], 2'b00};
            default: return s;
        endcase
    endfunction

    // Monitor: compare each produced receive word with the queue head.
    always @(negedge clk) begin
        if (rst_n && frame_stb) nstb++;
        if (rst_n && rx_stb) begin
            if (q_rx.size() == 0) begin
                chk("R6 unexpected rx_stb", rx_word, 16'hxxxx);
            end else begin
                logic [15:0] e;
                string       t;
                e = q_rx.pop_front();
                t = q_tag.pop_front();
                chk(t, rx_word, e);
            end
        end
    end

    task automatic write_cfg(input logic m, input logic l, input logic [1:0] w,
                             input logic txm, input logic rxm);
        @(negedge clk);
        cfg_master = m; cfg_long = l; cfg_width = w;
        cfg_tx_mute = txm; cfg_rx_mute = rxm; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        last_sync_t = 0;
        repeat (3) @(negedge clk);
    endtask

    // Codec model acting as clock/sync master (block in slave mode).
    task automatic slave_frame(input string tag, input logic l, input int slen, input logic [1:0] w,
                               input logic txm, input logic rxm,
                               input logic [15:0] txw, input logic [15:0] s);
        int          first, n, stb0;
        logic [15:0] got;
        first = l ? 0 : 1;
        n     = slot_n(w);
        got   = '0;
        stb0  = nstb;
        tx_word = txw;
        q_rx.push_back(exp_rx(w, rxm, s));
        q_tag.push_back({tag, " rx_word"});
        for (int k = 0; k < FB; k++) begin
            pcm_sync_i = l ? (k < slen) : (k == 0);
            repeat (HP) @(negedge clk);
            pcm_clk_i = 1'b1;
            pcm_din   = (k >= first && k < first + n) ? s[15 - (k - first)] : 1'b0;
            repeat (HP) @(negedge clk);
            if (k >= first && k < first + n) got[15 - (k - first)] = pcm_dout;
            pcm_clk_i = 1'b0;
        end
        chk({tag, " serial out"}, got, exp_serial(w, txm, txw));
        chk("R11 one frame_stb per frame", 16'(nstb - stb0), 16'd1);
    endtask

    // Codec model as clock/sync slave (block in master mode).
    task automatic master_frame(input string tag, input logic l, input logic [1:0] w,
                                input logic txm, input logic rxm,
                                input logic [15:0] txw, input logic [15:0] s);
        int          first, n, stb0, scnt, cyc;
        logic [15:0] got;
        logic        ps;
        first = l ? 0 : 1;
        n     = slot_n(w);
        got   = '0;
        scnt  = 0;
        stb0  = nstb;
        tx_word = txw;
        q_rx.push_back(exp_rx(w, rxm, s));
        q_tag.push_back({tag, " rx_word"});
        ps = pcm_sync_o;
        forever begin
            @(negedge clk);
            if (pcm_sync_o && !ps) break;
            ps = pcm_sync_o;
        end
        chk("R4 sync rises with bit clock", {15'd0, pcm_clk_o}, 16'd1);
        if (last_sync_t != 0)
            chk("R3 frame period", 16'(($time - last_sync_t) / CLK_PERIOD), 16'(FB * 2 * DIVH));
        last_sync_t = $time;
        for (int k = 0; k < FB; k++) begin
            pcm_din = (k >= first && k < first + n) ? s[15 - (k - first)] : 1'b0;
            if (pcm_sync_o) scnt++;
            cyc = 0;
            while (pcm_clk_o) begin @(negedge clk); cyc++; end
            if (k >= first && k < first + n) got[15 - (k - first)] = pcm_dout;
            if (k < FB - 1) begin
                while (!pcm_clk_o) begin @(negedge clk); cyc++; end
                if (k == 0) chk("R3 bit clock period", 16'(cyc), 16'(2 * DIVH));
            end
        end
        chk("R4 sync width", 16'(scnt), l ? 16'd3 : 16'd1);
        chk({tag, " serial out"}, got, exp_serial(w, txm, txw));
        chk("R11 one frame_stb per frame", 16'(nstb - stb0), 16'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 clock oe after reset", {15'd0, pcm_clk_oe}, 16'd0);
        chk("R1 sync oe after reset", {15'd0, pcm_sync_oe}, 16'd0);
        chk("R1 dout after reset", {15'd0, pcm_dout}, 16'd0);
        chk("R1 rx_word after reset", rx_word, 16'd0);
        chk("R1 strobes after reset", {14'd0, rx_stb, frame_stb}, 16'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 defaults: short format, 8-bit, no mute, slave
        slave_frame("R1 default 8-bit", 1'b0, 1, 2'b00, 1'b0, 1'b0, 16'h12A5, 16'hC300);
        slave_frame("R5 short 8-bit", 1'b0, 1, 2'b00, 1'b0, 1'b0, 16'h0F3C, 16'h5A00);

        write_cfg(1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
        slave_frame("R6 short 16-bit", 1'b0, 1, 2'b10, 1'b0, 1'b0, 16'hBEEF, 16'h8001);
        slave_frame("R5 short 16-bit", 1'b0, 1, 2'b10, 1'b0, 1'b0, 16'h7FFE, 16'h6C39);

        write_cfg(1'b0, 1'b0, 2'b01, 1'b0, 1'b0);
        slave_frame("R7 14-bit", 1'b0, 1, 2'b01, 1'b0, 1'b0, 16'hFFFF, 16'hA5A7);

        write_cfg(1'b0, 1'b1, 2'b11, 1'b0, 1'b0);
        slave_frame("R10 long sync 1 clk", 1'b1, 1, 2'b11, 1'b0, 1'b0, 16'hC0DE, 16'h1357);
        slave_frame("R10 long sync 10 clk", 1'b1, 10, 2'b11, 1'b0, 1'b0, 16'h2468, 16'hFACE);

        write_cfg(1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
        slave_frame("R7 long 8-bit", 1'b1, 3, 2'b00, 1'b0, 1'b0, 16'h7781, 16'h9900);

        write_cfg(1'b0, 1'b0, 2'b10, 1'b1, 1'b0);
        slave_frame("R8 tx mute", 1'b0, 1, 2'b10, 1'b1, 1'b0, 16'hFFFF, 16'h4321);
        write_cfg(1'b0, 1'b0, 2'b10, 1'b0, 1'b1);
        slave_frame("R9 rx mute", 1'b0, 1, 2'b10, 1'b0, 1'b1, 16'h8421, 16'hFFFF);

        // Master mode
        write_cfg(1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
        chk("R2 clock oe in master", {15'd0, pcm_clk_oe}, 16'd1);
        chk("R2 sync oe in master", {15'd0, pcm_sync_oe}, 16'd1);
        master_frame("R5 master short 16", 1'b0, 2'b10, 1'b0, 1'b0, 16'hA1B2, 16'h3C4D);
        master_frame("R6 master short 16", 1'b0, 2'b10, 1'b0, 1'b0, 16'h0001, 16'h8000);
        master_frame("R3 master short 16", 1'b0, 2'b10, 1'b0, 1'b0, 16'h5555, 16'hAAAA);

        write_cfg(1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
        write_cfg(1'b1, 1'b1, 2'b00, 1'b0, 1'b0);
        master_frame("R4 master long 8", 1'b1, 2'b00, 1'b0, 1'b0, 16'h00E7, 16'h8100);
        master_frame("R7 master long 8", 1'b1, 2'b00, 1'b0, 1'b0, 16'hFF18, 16'h7E00);

        write_cfg(1'b0, 1'b1, 2'b01, 1'b0, 1'b0);
        write_cfg(1'b1, 1'b1, 2'b01, 1'b0, 1'b0);
        master_frame("R7 master long 14", 1'b1, 2'b01, 1'b0, 1'b0, 16'h9ABF, 16'hF00F);

        write_cfg(1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
        chk("R2 clock oe back to slave", {15'd0, pcm_clk_oe}, 16'd0);

        repeat (50) @(negedge clk);
        chk("R6 all rx words delivered", 16'(q_rx.size()), 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule